// File: doc/BRIEF.md
# I/O Line Buffer Controller

This block connects a narrow I/O bus master, which issues single 32-bit word reads and writes, to a system-memory port that only moves whole 32-byte lines. Reads are handled a line at a time. When a read misses, the block fetches the full line into a read buffer. Further reads that land in that line are answered from the buffer and cause no memory traffic. Writes are merged into a separate write buffer. That buffer goes to memory as a single line write once all of its words are filled, or earlier when something forces it out.

The block holds two line buffers, one for reads and one for writes. Each has a line tag and a valid flag. The write buffer also has one fill bit per word, and that mask travels with every line write so memory updates only the words that were written. The block forces the write buffer out early in three cases: a write to a different line, a read that touches the pending write line, and the drain input. An invalidate input drops the read copy when another agent has changed memory. While a line transfer is open on the memory side, the master is held off.

Top module: `iolb_ctrl`

## Requirements
- R1: After synchronous reset, `req_ready` is high while idle, `mem_req` and `rsp_valid` are low, and both buffers are empty, so the first read goes to memory.
- R2: A read that misses issues exactly one memory read whose `mem_addr` is request address bits [31:5]. The requested word is word index addr[4:2] of `mem_rdata`, where word i sits in bits [32*i+31:32*i]. `rsp_valid` pulses with that word one cycle after the `mem_ack` cycle.
- R3: A read whose address falls in the valid read line gets its word on `rsp_valid` one cycle after acceptance, with no memory access.
- R4: An accepted write that leaves its line incomplete causes no memory access.
- R5: When the eighth distinct word of a write line is filled, one memory write of that line is issued with `mem_wmask` = 8'hFF, where bit i enables word i.
- R6: A write to a line other than the pending partial line is held off until the pending line has been written with a mask of exactly its filled words. The new word then starts a fresh line.
- R7: A read to the line held in the write buffer is held off until that line is written to memory. The read then returns the newly written data.
- R8: A one-cycle `inval` pulse clears the read line on the next clock, so the next read to that line misses.
- R9: Raising `drain` while a partial line is pending writes it to memory with its fill mask.
- R10: `req_ready` is low whenever `mem_req` is high. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.
- R11: A write accepted to the line held in the read buffer drops the read copy, so a later read of that line fetches it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Master request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Read data pulse |
| rsp_data | output | 32 | Read data |
| drain | input | 1 | Force the pending write line out |
| inval | input | 1 | Drop the read line |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 27 | Line address (byte address bits [31:5]) |
| mem_wmask | output | 8 | Per-word write enable |
| mem_wdata | output | 256 | Line write data |
| mem_ack | input | 1 | Transfer complete, read data valid |
| mem_rdata | input | 256 | Line read data |

## Verification
The bench uses the default parameters: 32-bit words, eight words per line and 32-bit addresses. With these values the line address is bits [31:5], so a sixteen-line memory model at small addresses can reach every word index. It also covers complete-line write gathering, flushes with partial masks, and overlap between the read and write buffers. The model acknowledges each transfer a fixed three cycles after the request appears, which makes the miss latency an exact cycle count the bench can check.

// File: rtl/iolb_pkg.sv
package iolb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_FLUSH = 2'd2
   } iolb_state_e;
endpackage

// File: rtl/iolb_rd_line.sv
module iolb_rd_line #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int TAG_W  = 27
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          inval,
   input  logic                          drop,
   input  logic                          load,
   input  logic [TAG_W-1:0]              load_tag,
   input  logic [WORDS-1:0][DATA_W-1:0]  load_data,
   input  logic [TAG_W-1:0]              look_tag,
   input  logic [$clog2(WORDS)-1:0]      look_sel,
   output logic                          hit,
   output logic [DATA_W-1:0]             word,
   output logic                          valid_o
);
   logic                         valid_q;
   logic [TAG_W-1:0]             tag_q;
   logic [WORDS-1:0][DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst)
         valid_q <= 1'b0;
      else if (inval || drop)
         valid_q <= 1'b0;
      else if (load)
         valid_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (load) begin
         tag_q  <= load_tag;
         data_q <= load_data;
      end
   end

   assign hit     = valid_q && (tag_q == look_tag);
   assign word    = data_q[look_sel];
   assign valid_o = valid_q;

   assert_inval_clears_R8: assert property (@(posedge clk) disable iff (rst)
      inval |=> !valid_q);
endmodule

// File: rtl/iolb_wr_gather.sv
module iolb_wr_gather #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int TAG_W  = 27
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          put,
   input  logic [TAG_W-1:0]              put_tag,
   input  logic [$clog2(WORDS)-1:0]      put_sel,
   input  logic [DATA_W-1:0]             put_word,
   input  logic                          clear,
   output logic                          valid_o,
   output logic [TAG_W-1:0]              tag_o,
   output logic [WORDS-1:0]              mask_o,
   output logic [WORDS-1:0][DATA_W-1:0]  line_o
);
   localparam int IDX_W = $clog2(WORDS);

   logic [WORDS-1:0]  mask_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] data_q [WORDS];

   always_ff @(posedge clk) begin
      if (rst)
         mask_q <= '0;
      else if (clear)
         mask_q <= '0;
      else if (put)
         mask_q[put_sel] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (put)
         tag_q <= put_tag;
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (put && put_sel == IDX_W'(g))
            data_q[g] <= put_word;
      end
      assign line_o[g] = data_q[g];
   end

   assign valid_o = |mask_q;
   assign tag_o   = tag_q;
   assign mask_o  = mask_q;

   assert_single_line_R6: assert property (@(posedge clk) disable iff (rst)
      (put && valid_o) |-> (put_tag == tag_q));
endmodule

// File: rtl/iolb_ctrl.sv
module iolb_ctrl
   import iolb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 8
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_we,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [DATA_W-1:0]          req_wdata,
   output logic                       rsp_valid,
   output logic [DATA_W-1:0]          rsp_data,
   input  logic                       drain,
   input  logic                       inval,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [ADDR_W-$clog2(WORDS*DATA_W/8)-1:0] mem_addr,
   output logic [WORDS-1:0]           mem_wmask,
   output logic [WORDS*DATA_W-1:0]    mem_wdata,
   input  logic                       mem_ack,
   input  logic [WORDS*DATA_W-1:0]    mem_rdata
);
   localparam int WB    = $clog2(DATA_W / 8);
   localparam int OFF   = $clog2(WORDS * DATA_W / 8);
   localparam int IDX_W = $clog2(WORDS);
   localparam int TAG_W = ADDR_W - OFF;

   initial begin
      assert (WORDS >= 2 && (WORDS & (WORDS - 1)) == 0)
         else $error("WORDS must be a power of two, at least 2");
      assert (DATA_W >= 8 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("DATA_W must be a power of two bytes");
      assert (ADDR_W > OFF) else $error("ADDR_W too small for a line");
   end

   iolb_state_e state_q;
   logic [TAG_W-1:0] fill_tag_q;
   logic [IDX_W-1:0] fill_sel_q;

   logic [TAG_W-1:0] req_tag;
   logic [IDX_W-1:0] req_sel;
   logic             unused_lowbits;
   assign req_tag        = req_addr[ADDR_W-1:OFF];
   assign req_sel        = req_addr[OFF-1:WB];
   assign unused_lowbits = ^req_addr[WB-1:0];

   logic                         rd_hit, rd_valid;
   logic [DATA_W-1:0]            rd_word;
   logic                         wr_valid;
   logic [TAG_W-1:0]             wr_tag;
   logic [WORDS-1:0]             wr_mask;
   logic [WORDS-1:0][DATA_W-1:0] wr_line;
   logic [WORDS-1:0][DATA_W-1:0] fill_words;
   assign fill_words = mem_rdata;

   logic need_flush, accept, put, rd_acc, fill_done, flush_done, line_full;
   logic [WORDS-1:0] sel_bit;

   assign need_flush = wr_valid &&
      (drain || (req_valid && (req_we ? (req_tag != wr_tag) : (req_tag == wr_tag))));
   assign req_ready  = (state_q == ST_IDLE) && !need_flush;
   assign accept     = req_valid && req_ready;
   assign put        = accept && req_we;
   assign rd_acc     = accept && !req_we;
   assign fill_done  = (state_q == ST_FILL) && mem_ack;
   assign flush_done = (state_q == ST_FLUSH) && mem_ack;
   assign sel_bit    = WORDS'(1) << req_sel;
   assign line_full  = &(wr_mask | sel_bit);

   iolb_rd_line #(.DATA_W(DATA_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_rd (
      .clk(clk), .rst(rst), .inval(inval), .drop(put && rd_hit),
      .load(fill_done), .load_tag(fill_tag_q), .load_data(fill_words),
      .look_tag(req_tag), .look_sel(req_sel),
      .hit(rd_hit), .word(rd_word), .valid_o(rd_valid)
   );

   iolb_wr_gather #(.DATA_W(DATA_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_wr (
      .clk(clk), .rst(rst), .put(put), .put_tag(req_tag), .put_sel(req_sel),
      .put_word(req_wdata), .clear(flush_done),
      .valid_o(wr_valid), .tag_o(wr_tag), .mask_o(wr_mask), .line_o(wr_line)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (need_flush)
                  state_q <= ST_FLUSH;
               else if (rd_acc && !rd_hit)
                  state_q <= ST_FILL;
               else if (put && line_full)
                  state_q <= ST_FLUSH;
            end
            ST_FILL:  if (mem_ack) state_q <= ST_IDLE;
            ST_FLUSH: if (mem_ack) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rd_acc && !rd_hit) begin
         fill_tag_q <= req_tag;
         fill_sel_q <= req_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         rsp_valid <= 1'b0;
      else
         rsp_valid <= (rd_acc && rd_hit) || fill_done;
   end

   always_ff @(posedge clk) begin
      if (rd_acc && rd_hit)
         rsp_data <= rd_word;
      else if (fill_done)
         rsp_data <= fill_words[fill_sel_q];
   end

   assign mem_req   = (state_q != ST_IDLE);
   assign mem_we    = (state_q == ST_FLUSH);
   assign mem_addr  = mem_we ? wr_tag : fill_tag_q;
   assign mem_wmask = mem_we ? wr_mask : '0;
   assign mem_wdata = wr_line;

   assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
   assert_busy_stall_R10: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> !req_ready);
   assert_hit_rsp_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_acc && rd_hit) |=> rsp_valid);
   assert_fill_rsp_R2: assert property (@(posedge clk) disable iff (rst)
      (mem_req && !mem_we && mem_ack) |=> (rsp_valid && !mem_req));
   assert_wr_gathered_R4: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we) |-> (wr_valid && mem_wmask != '0));
endmodule

// File: tb/tb_iolb_ctrl.sv
module tb_iolb_ctrl;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0, req_we = 1'b0, drain = 1'b0, inval = 1'b0;
   logic [31:0]  req_addr = '0, req_wdata = '0;
   logic         req_ready, rsp_valid, mem_req, mem_we;
   logic [31:0]  rsp_data;
   logic [26:0]  mem_addr;
   logic [7:0]   mem_wmask;
   logic [255:0] mem_wdata;
   logic         mem_ack;
   logic [255:0] mem_rdata;

   always #4 clk = ~clk;

   iolb_ctrl dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .drain(drain), .inval(inval),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wmask(mem_wmask), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   int checks = 0, errors = 0;
   int nrd = 0, nwr = 0, cnt = 0, stall_bad = 0;
   logic [7:0]   last_mask = '0;
   logic [6:0]   last_rd_line = '0, last_wr_line = '0;
   logic [255:0] mem_line [16];
   logic [31:0]  shadow [16][8];

   function automatic logic [31:0] pattern(int ln, int w);
      return 32'hA500_0000 | (ln << 8) | w;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         mem_ack <= 1'b0;
         cnt = 0;
         for (int l = 0; l < 16; l++)
            for (int w = 0; w < 8; w++)
               mem_line[l][w*32 +: 32] = pattern(l, w);
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         cnt = 0;
      end else if (mem_req) begin
         if (cnt == 2) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
               for (int w = 0; w < 8; w++)
                  if (mem_wmask[w]) mem_line[mem_addr[3:0]][w*32 +: 32] = mem_wdata[w*32 +: 32];
               nwr++;
               last_mask    <= mem_wmask;
               last_wr_line <= mem_addr[6:0];
            end else begin
               mem_rdata <= mem_line[mem_addr[3:0]];
               nrd++;
               last_rd_line <= mem_addr[6:0];
            end
         end else begin
            cnt = cnt + 1;
         end
      end
   end

   always @(negedge clk) if (!rst && mem_req && req_ready) stall_bad++;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_op(input logic we, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rdata, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = {20'h0, a}; req_wdata = d;
      #1;
      while (!req_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1; rdata = '0;
      if (!we) begin
         while (!rsp_valid && lat < 40) begin @(negedge clk); lat++; end
         rdata = rsp_data;
      end
      if (we) shadow[a[8:5]][a[4:2]] = d;
      repeat (6) @(negedge clk);
   endtask

   // {we, addr[11:0], data, reads added, writes added, last write mask}
   localparam int NV = 13;
   localparam logic [56:0] VEC [NV] = '{
      {1'b0, 12'h004, 32'h0,  2'd1, 2'd0, 8'h00},
      {1'b0, 12'h008, 32'h0,  2'd0, 2'd0, 8'h00},
      {1'b0, 12'h01C, 32'h0,  2'd0, 2'd0, 8'h00},
      {1'b0, 12'h024, 32'h0,  2'd1, 2'd0, 8'h00},
      {1'b1, 12'h040, 32'h11, 2'd0, 2'd0, 8'h00},
      {1'b1, 12'h044, 32'h22, 2'd0, 2'd0, 8'h00},
      {1'b1, 12'h060, 32'h33, 2'd0, 2'd1, 8'h03},
      {1'b0, 12'h040, 32'h0,  2'd1, 2'd0, 8'h00},
      {1'b0, 12'h060, 32'h0,  2'd1, 2'd1, 8'h01},
      {1'b0, 12'h100, 32'h0,  2'd1, 2'd0, 8'h00},
      {1'b1, 12'h104, 32'h55, 2'd0, 2'd0, 8'h00},
      {1'b0, 12'h104, 32'h0,  2'd1, 2'd1, 8'h02},
      {1'b0, 12'h108, 32'h0,  2'd0, 2'd0, 8'h00}
   };

   initial begin
      logic [31:0] rd;
      int lat, r0, w0;
      for (int l = 0; l < 16; l++)
         for (int w = 0; w < 8; w++) shadow[l][w] = pattern(l, w);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 ready after reset", {63'h0, req_ready}, 64'h1);
      chk("R1 mem_req after reset", {63'h0, mem_req}, 64'h0);
      chk("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         logic [56:0] v;
         logic [11:0] a;
         v = VEC[i]; a = v[55:44];
         r0 = nrd; w0 = nwr;
         do_op(v[56], a, v[43:12], rd, lat);
         chk($sformatf("R2/R3 reads vec %0d", i), 64'(nrd - r0), 64'(v[11:10]));
         chk($sformatf("R4/R6/R7 writes vec %0d", i), 64'(nwr - w0), 64'(v[9:8]));
         if (v[9:8] != 0) chk($sformatf("R6 mask vec %0d", i), 64'(last_mask), 64'(v[7:0]));
         if (!v[56]) begin
            chk($sformatf("R2 R3 R7 data vec %0d", i), 64'(rd), 64'(shadow[a[8:5]][a[4:2]]));
            if (v[11:10] != 0) begin
               chk($sformatf("R2 line addr vec %0d", i), 64'(last_rd_line), 64'(a[11:5]));
               chk($sformatf("R2 miss latency vec %0d", i), 64'(lat), 64'd5);
            end else begin
               chk($sformatf("R3 hit latency vec %0d", i), 64'(lat), 64'd1);
            end
         end
      end

      // R8: invalidate drops the read line
      @(negedge clk); inval = 1'b1; @(negedge clk); inval = 1'b0;
      r0 = nrd;
      do_op(1'b0, 12'h108, 32'h0, rd, lat);
      chk("R8 read after inval misses", 64'(nrd - r0), 64'd1);
      chk("R8 data", 64'(rd), 64'(shadow[8][2]));

      // R11: write into the read line drops the read copy
      r0 = nrd; w0 = nwr;
      do_op(1'b1, 12'h10C, 32'h66, rd, lat);
      @(negedge clk); drain = 1'b1; repeat (8) @(negedge clk); drain = 1'b0;
      repeat (2) @(negedge clk);
      do_op(1'b0, 12'h108, 32'h0, rd, lat);
      chk("R11 refetch after write", 64'(nrd - r0), 64'd1);
      chk("R11 data", 64'(rd), 64'(shadow[8][2]));

      // R9: drain writes out a partial line
      w0 = nwr;
      do_op(1'b1, 12'h1C0, 32'h77, rd, lat);
      chk("R4 single write held", 64'(nwr - w0), 64'd0);
      @(negedge clk); drain = 1'b1; repeat (8) @(negedge clk); drain = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 drain writes", 64'(nwr - w0), 64'd1);
      chk("R9 drain mask", 64'(last_mask), 64'h01);
      chk("R9 drain line", 64'(last_wr_line), 64'h0E);
      do_op(1'b0, 12'h1C0, 32'h0, rd, lat);
      chk("R9 data in memory", 64'(rd), 64'h77);

      // R5: complete line gathered into one write
      w0 = nwr;
      for (int w = 0; w < 8; w++) begin
         do_op(1'b1, 12'h180 + 12'(w * 4), 32'hC0DE_0000 + 32'(w), rd, lat);
         if (w < 7) chk("R4 no partial write", 64'(nwr - w0), 64'd0);
      end
      chk("R5 one full write", 64'(nwr - w0), 64'd1);
      chk("R5 full mask", 64'(last_mask), 64'hFF);
      chk("R5 line addr", 64'(last_wr_line), 64'h0C);
      do_op(1'b0, 12'h19C, 32'h0, rd, lat);
      chk("R5 read back", 64'(rd), 64'hC0DE_0007);

      chk("R10 ready low during memory transfer", 64'(stall_bad), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule